// File: doc/BRIEF.md
# Eight-Bit Addressable Latch Decoder

This block stores eight single-bit values that are written one at a time through a shared data input. A 3-bit address picks which bit is targeted. Two active-low controls, a common enable and a common clear, combine into four modes. In write mode the addressed bit takes the data input and the other bits keep their values. In hold mode all bits are frozen. In decoder mode the addressed bit takes the data input and every other bit is forced low. In clear mode all bits are forced low.

The block is modelled synchronously. Data, address and both controls are sampled on each rising edge of the system clock, and the outputs show the result from that edge on. Address glitch protection is left to the user of the block: a valid address must be present while the enable is active. An asynchronous active-low reset sets all outputs low.

Top module: `addr_latch_dec`

## Requirements
- R1: While rst_ni is low, all bits of q_o are 0, whatever the state was before reset.
- R2: addr_i holds a binary index, with addr_i[2] as the most significant bit. The value k selects q_o[k], so 3'b000 selects bit 0 and 3'b111 selects bit 7.
- R3: Write mode is en_ni=0 and clr_ni=1. In this mode, on a rising edge, q_o[addr_i] takes the value of d_i.
- R4: In write mode, every bit other than the addressed one keeps its previous value.
- R5: Hold mode is en_ni=1 and clr_ni=1. In this mode all eight bits keep their values, whatever d_i and addr_i do.
- R6: Decoder mode is en_ni=0 and clr_ni=0. In this mode, on a rising edge, q_o[addr_i] takes d_i and all other bits become 0.
- R7: Clear mode is en_ni=1 and clr_ni=0. In this mode, on a rising edge, all eight bits become 0.
- R8: After en_ni returns high, the bit written last keeps the value of d_i from the last edge at which en_ni was low.
- R9: If addr_i changes while en_ni stays low in write mode, the previously addressed bit keeps its last captured value. The newly addressed bit follows d_i from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| d_i | input | 1 | Shared data bit |
| addr_i | input | ADDR_W (3) | Index of the targeted bit |
| en_ni | input | 1 | Common enable, active low |
| clr_ni | input | 1 | Common clear, active low |
| q_o | output | 2**ADDR_W (8) | Stored bits |

## Verification
The bench builds the block with its default ADDR_W of 3, which gives eight outputs. At this size the bench can cover every combination of mode, address and data value, each applied to several preloaded bit patterns. Each transition is compared against an expected word that the bench computes from the mode rules. This covers the case where one bit is set while all the others are clear, the reverse case, and address moves while the enable stays low.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } mode_e;

  function automatic mode_e get_mode(input logic en_n, input logic clr_n);
    case ({clr_n, en_n})
      2'b10:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DECODE;
      default: return MODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/addr_onehot_dec.sv
module addr_onehot_dec #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_OUT-1:0]  sel_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/latch_cell.sv
module latch_cell
  import addr_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  sel_i,
  input  logic  d_i,
  output logic  q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    unique case (mode_i)
      MODE_WRITE:  if (sel_i) q_d = d_i;
      MODE_HOLD:   q_d = q_q;
      MODE_DECODE: q_d = sel_i & d_i;
      MODE_CLEAR:  q_d = 1'b0;
      default:     q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_ni,
  input  logic              clr_ni,
  output logic [N_OUT-1:0]  q_o
);
  mode_e            mode;
  logic [N_OUT-1:0] sel;

  assign mode = get_mode(en_ni, clr_ni);

  addr_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    latch_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .sel_i  (sel[i]),
      .d_i    (d_i),
      .q_o    (q_o[i])
    );
  end

  AST_WRITE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |=> q_o[$past(addr_i)] == $past(d_i)); // R3
  AST_KEEP_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_ni) |=> ((q_o ^ $past(q_o)) & ~$past(sel)) == '0); // R4
  AST_HOLD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && en_ni) |=> $stable(q_o)); // R5
  AST_DECODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !en_ni) |=> $onehot0(q_o)); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && en_ni) |=> q_o == '0); // R7
endmodule

// File: tb/tb_addr_latch_dec.sv
module tb_addr_latch_dec;
  localparam int ADDR_W = 3;
  localparam int N_OUT  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              d_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              en_ni = 1'b1;
  logic              clr_ni = 1'b1;
  logic [N_OUT-1:0]  q_o;
  logic [N_OUT-1:0]  exp_q = '0;
  int                n_chk = 0;
  int                n_fail = 0;

  addr_latch_dec #(.ADDR_W(ADDR_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic [N_OUT-1:0] exp);
    n_chk++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
    end
  endtask

  // drive one cycle at negedge, model it, check at next negedge
  task automatic step(input logic en, input logic clr, input int a,
                      input logic d, input string req);
    logic [N_OUT-1:0] m;
    m = N_OUT'(1) << a;
    en_ni = en; clr_ni = clr; addr_i = ADDR_W'(a); d_i = d;
    case ({clr, en})
      2'b10: exp_q = d ? (exp_q | m) : (exp_q & ~m);
      2'b11: exp_q = exp_q;
      2'b00: exp_q = d ? m : '0;
      default: exp_q = '0;
    endcase
    @(negedge clk_i);
    check(req, exp_q);
  endtask

  task automatic load(input logic [N_OUT-1:0] pat);
    for (int a = 0; a < N_OUT; a++) step(1'b0, 1'b1, a, pat[a], "R9");
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: q_o=%b expected=finish", q_o);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [N_OUT-1:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;
    @(negedge clk_i);
    check("R1", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: single one at each index from cleared state
    for (int a = 0; a < N_OUT; a++) begin
      step(1'b1, 1'b0, 0, 1'b0, "R7");
      step(1'b0, 1'b1, a, 1'b1, "R2");
      check("R2", N_OUT'(1) << a);
    end

    // R8: capture then release enable with changing data
    step(1'b0, 1'b1, 2, 1'b1, "R3");
    step(1'b1, 1'b1, 2, 1'b0, "R8");
    check("R8", exp_q);
    step(1'b1, 1'b1, 5, 1'b1, "R8");

    // exhaustive sweep: pattern x mode x address x data
    for (int p = 0; p < 4; p++)
      for (int md = 0; md < 4; md++)
        for (int a = 0; a < N_OUT; a++)
          for (int d = 0; d < 2; d++) begin
            load(pats[p]);
            case (md)
              0: step(1'b0, 1'b1, a, d[0], "R3 R4");
              1: step(1'b1, 1'b1, a, d[0], "R5");
              2: step(1'b0, 1'b0, a, d[0], "R6");
              default: step(1'b1, 1'b0, a, d[0], "R7");
            endcase
            step(1'b1, 1'b1, (a + 3) % N_OUT, ~d[0], "R5");
          end

    // R9: address walks with enable held low
    load(8'h00);
    step(1'b0, 1'b1, 1, 1'b1, "R9");
    step(1'b0, 1'b1, 6, 1'b0, "R9");
    step(1'b0, 1'b1, 6, 1'b1, "R9");
    check("R9", 8'b0100_0010);

    // R1: asynchronous reset mid-operation
    load(8'hFF);
    #1 rst_ni = 1'b0;
    #1 check("R1", '0);
    exp_q = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 0, 1'b1, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule